// File: doc/BRIEF.md
# Serial Port Bit-Rate and Character-Time Generator

This block derives the bit-rate timing of a serial port from one fixed input clock. Three configuration registers are written through a small write port: a mode register, a clock divisor and a bit divisor. The bit period comes from two dividers in series. The first divides the selected clock by the clock divisor. The second divides the result by the bit divisor plus one. A bit in the mode register can insert a divide-by-8 prescaler ahead of both dividers.

The mode register also encodes the character format: data length, parity and stop bits. The block decodes these fields onto output pins and computes the total frame length in bit periods. It raises `baudTick` for one cycle per bit period. It raises `charDone` on every tick that closes a full character, so a transmitter can pace whole characters from it and a receive-timeout counter can count it. Any write to one of the three registers restarts every counter from zero, so the first tick under the new setting arrives exactly one full period after the write.

Top module: `uart_frame_timer`

## Requirements
- R1: After reset the mode register is 0 (8 data bits, even parity, two stop bits, frame length 12, no prescale). The clock divisor is 15 and the bit divisor is 0. `baudTick` and `charDone` are low.
- R2: With clock divisor D >= 2 and bit divisor B, `baudTick` is a one-cycle pulse every S*D*(B+1) clock cycles. S is 8 when mode bit 0 is 1 and 1 when mode bit 0 is 0.
- R3: `dataBits` decodes mode bits [2:1] as follows: 2'b11 gives 6, 2'b10 gives 7, and any other code gives 8.
- R4: Mode bits [5:3] set parity: 3'b000 gives even (`parityOn`=1, `parityOdd`=0), 3'b001 gives odd (`parityOn`=1, `parityOdd`=1), and any other value gives none (`parityOn`=0, `parityOdd`=0).
- R5: `stopBits` is 1 when mode bits [7:6] are 2'b11 and 2 for any other code.
- R6: `frameBits` equals 1 + `dataBits` + `parityOn` + `stopBits`.
- R7: `charDone` pulses together with every `frameBits`-th `baudTick` after the last restart, and never without a tick.
- R8: A clock divisor of 0 or 1 stops `baudTick` and `charDone` completely.
- R9: A write with `wrSel` 0 (mode, `wrData[7:0]`), 1 (clock divisor) or 2 (bit divisor) updates that register at the clock edge and clears all counters. The first tick then comes one full period after that edge, and the character count starts again.
- R10: A write with `wrSel` 3 changes no register and does not restart the counters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Register select: 0 mode, 1 clock divisor, 2 bit divisor, 3 unused |
| wrData | input | DATA_W | Write data |
| baudTick | output | 1 | One-cycle pulse per bit period |
| charDone | output | 1 | One-cycle pulse at the end of each character time |
| dataBits | output | 4 | Decoded data length |
| parityOn | output | 1 | Parity bit present |
| parityOdd | output | 1 | Parity is odd |
| stopBits | output | 2 | Number of stop bits |
| frameBits | output | 4 | Bits per character, start bit included |

## Verification
The hardest case to reach is the joint cadence of the prescaler, both dividers and the frame counter. With the prescaler on, a character spans hundreds of cycles, and an off-by-one in any of the four stages appears only at the last tick of a frame. The bench sets a small divisor pair with prescaling on and runs past two full characters. It also writes a divisor again partway through a character, to show that the tick phase and the character count both restart. A reference model that counts cycles since the last restart is compared with both strobes on every clock.

// File: rtl/uft_pkg.sv
package uft_pkg;

  localparam int MODE_W = 8;

  typedef enum logic [1:0] {
    SEL_MODE   = 2'd0,
    SEL_CLKDIV = 2'd1,
    SEL_BITDIV = 2'd2,
    SEL_SPARE  = 2'd3
  } cfgSel_e;

  // strobes from control to the divider datapath
  typedef struct packed {
    logic reload;
    logic prescaleOn;
    logic tickAllowed;
  } timerCtl_t;

  typedef struct packed {
    logic [3:0] dataBits;
    logic       parityOn;
    logic       parityOdd;
    logic [1:0] stopBits;
    logic [3:0] frameBits;
  } frameFmt_t;

  function automatic frameFmt_t decodeMode(input logic [MODE_W-1:0] m);
    frameFmt_t f;
    case (m[2:1])
      2'b11:   f.dataBits = 4'd6;
      2'b10:   f.dataBits = 4'd7;
      default: f.dataBits = 4'd8;
    endcase
    f.parityOn  = (m[5:4] == 2'b00);
    f.parityOdd = f.parityOn & m[3];
    f.stopBits  = (m[7:6] == 2'b11) ? 2'd1 : 2'd2;
    f.frameBits = 4'd1 + f.dataBits + {3'b000, f.parityOn} + {2'b00, f.stopBits};
    return f;
  endfunction

endpackage

// File: rtl/uft_ctrl.sv
module uft_ctrl
  import uft_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int CDIV_W   = 16,
  parameter int BDIV_W   = 8,
  parameter int CDIV_RST = 15,
  parameter int BDIV_RST = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [DATA_W-1:0] wrData,
  output timerCtl_t         ctl,
  output logic [CDIV_W-1:0] clkDiv,
  output logic [BDIV_W-1:0] bitDiv,
  output frameFmt_t         fmt
);

  logic [MODE_W-1:0] modeQ;
  logic [CDIV_W-1:0] clkDivQ;
  logic [BDIV_W-1:0] bitDivQ;
  cfgSel_e           selNow;

  assign selNow = cfgSel_e'(wrSel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ   <= '0;
      clkDivQ <= CDIV_W'(CDIV_RST);
      bitDivQ <= BDIV_W'(BDIV_RST);
    end else if (wrEn) begin
      case (selNow)
        SEL_MODE:   modeQ   <= wrData[MODE_W-1:0];
        SEL_CLKDIV: clkDivQ <= wrData[CDIV_W-1:0];
        SEL_BITDIV: bitDivQ <= wrData[BDIV_W-1:0];
        default:    ;
      endcase
    end
  end

  always_comb begin
    ctl.reload      = wrEn && (selNow != SEL_SPARE);
    ctl.prescaleOn  = modeQ[0];
    ctl.tickAllowed = (clkDivQ >= CDIV_W'(2));
  end

  assign clkDiv = clkDivQ;
  assign bitDiv = bitDivQ;
  assign fmt    = decodeMode(modeQ);

endmodule

// File: rtl/uft_timer.sv
module uft_timer
  import uft_pkg::*;
#(
  parameter int CDIV_W   = 16,
  parameter int BDIV_W   = 8,
  parameter int PRESCALE = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  timerCtl_t         ctl,
  input  logic [CDIV_W-1:0] clkDiv,
  input  logic [BDIV_W-1:0] bitDiv,
  input  logic [3:0]        frameBits,
  output logic              baudTick,
  output logic              charDone
);

  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic              preEn;
  logic [CDIV_W-1:0] cdCnt;
  logic [BDIV_W-1:0] bdCnt;
  logic [3:0]        frameCnt;
  logic              cdWrap, bdWrap, frWrap;

  generate
    if (PRESCALE > 1) begin : gPre
      logic [PRE_W-1:0] preCnt;
      logic             preLast;
      assign preLast = (preCnt == PRE_W'(PRESCALE - 1));
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) preCnt <= '0;
        else if (ctl.reload || !ctl.prescaleOn) preCnt <= '0;
        else if (preLast) preCnt <= '0;
        else preCnt <= preCnt + PRE_W'(1);
      end
      assign preEn = !ctl.prescaleOn || preLast;
    end else begin : gNoPre
      assign preEn = 1'b1;
    end
  endgenerate

  assign cdWrap = ctl.tickAllowed && preEn && (cdCnt == clkDiv - CDIV_W'(1));
  assign bdWrap = cdWrap && (bdCnt == bitDiv);
  assign frWrap = bdWrap && (frameCnt == frameBits - 4'd1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cdCnt    <= '0;
      bdCnt    <= '0;
      frameCnt <= '0;
      baudTick <= 1'b0;
      charDone <= 1'b0;
    end else if (ctl.reload) begin
      cdCnt    <= '0;
      bdCnt    <= '0;
      frameCnt <= '0;
      baudTick <= 1'b0;
      charDone <= 1'b0;
    end else begin
      if (ctl.tickAllowed && preEn)
        cdCnt <= cdWrap ? '0 : cdCnt + CDIV_W'(1);
      if (cdWrap)
        bdCnt <= bdWrap ? '0 : bdCnt + BDIV_W'(1);
      if (bdWrap)
        frameCnt <= frWrap ? 4'd0 : frameCnt + 4'd1;
      baudTick <= bdWrap;
      charDone <= frWrap;
    end
  end

endmodule

// File: rtl/uart_frame_timer.sv
module uart_frame_timer
  import uft_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int CDIV_W   = 16,
  parameter int BDIV_W   = 8,
  parameter int PRESCALE = 8,
  parameter int CDIV_RST = 15,
  parameter int BDIV_RST = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [DATA_W-1:0] wrData,
  output logic              baudTick,
  output logic              charDone,
  output logic [3:0]        dataBits,
  output logic              parityOn,
  output logic              parityOdd,
  output logic [1:0]        stopBits,
  output logic [3:0]        frameBits
);

  timerCtl_t         ctl;
  logic [CDIV_W-1:0] clkDivQ;
  logic [BDIV_W-1:0] bitDivQ;
  frameFmt_t         fmt;

  uft_ctrl #(
    .DATA_W(DATA_W), .CDIV_W(CDIV_W), .BDIV_W(BDIV_W),
    .CDIV_RST(CDIV_RST), .BDIV_RST(BDIV_RST)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .ctl(ctl), .clkDiv(clkDivQ), .bitDiv(bitDivQ), .fmt(fmt)
  );

  uft_timer #(
    .CDIV_W(CDIV_W), .BDIV_W(BDIV_W), .PRESCALE(PRESCALE)
  ) uTimer (
    .clk(clk), .rstN(rstN), .ctl(ctl), .clkDiv(clkDivQ), .bitDiv(bitDivQ),
    .frameBits(fmt.frameBits), .baudTick(baudTick), .charDone(charDone)
  );

  assign dataBits  = fmt.dataBits;
  assign parityOn  = fmt.parityOn;
  assign parityOdd = fmt.parityOdd;
  assign stopBits  = fmt.stopBits;
  assign frameBits = fmt.frameBits;

endmodule

// File: rtl/uft_checker.sv
module uft_checker #(
  parameter int CDIV_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [1:0]        wrSel,
  input logic              baudTick,
  input logic              charDone,
  input logic [3:0]        dataBits,
  input logic              parityOn,
  input logic [1:0]        stopBits,
  input logic [3:0]        frameBits,
  input logic [CDIV_W-1:0] clkDiv
);

  assert_tick_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    baudTick |=> !baudTick);

  assert_data_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    (dataBits >= 4'd6) && (dataBits <= 4'd8));

  assert_frame_sum_R6: assert property (@(posedge clk) disable iff (!rstN)
    frameBits == 4'd1 + dataBits + {3'b000, parityOn} + {2'b00, stopBits});

  assert_char_on_tick_R7: assert property (@(posedge clk) disable iff (!rstN)
    charDone |-> baudTick);

  assert_no_tick_low_div_R8: assert property (@(posedge clk) disable iff (!rstN)
    (clkDiv < CDIV_W'(2)) |-> (!baudTick && !charDone));

  assert_restart_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel != 2'd3) |=> (!baudTick && !charDone));

  assert_spare_ignored_R10: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == 2'd3) |=> ($stable(frameBits) && $stable(clkDiv)));

endmodule

bind uart_frame_timer uft_checker #(.CDIV_W(CDIV_W)) uChecker (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel),
  .baudTick(baudTick), .charDone(charDone), .dataBits(dataBits),
  .parityOn(parityOn), .stopBits(stopBits), .frameBits(frameBits),
  .clkDiv(clkDivQ)
);

// File: tb/uart_frame_timer_test.sv
module uart_frame_timer_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrSel = 2'd0;
  logic [15:0] wrData = 16'd0;
  logic        baudTick, charDone, parityOn, parityOdd;
  logic [3:0]  dataBits, frameBits;
  logic [1:0]  stopBits;

  always #5 clk = ~clk;

  uart_frame_timer uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .baudTick(baudTick), .charDone(charDone), .dataBits(dataBits),
    .parityOn(parityOn), .parityOdd(parityOdd), .stopBits(stopBits),
    .frameBits(frameBits)
  );

  int    checks = 0;
  int    fails = 0;
  string curReq = "R1";
  bit    compareOn = 0;
  int    tickSeen = 0;
  int    charSeen = 0;

  // reference state
  int         since = 0;
  logic [7:0] mM = 8'd0;
  int         cdM = 15;
  int         bdM = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int refData(input logic [7:0] m);
    if (m[2:1] == 2'b11) return 6;
    if (m[2:1] == 2'b10) return 7;
    return 8;
  endfunction
  function automatic int refParOn(input logic [7:0] m);
    return (m[5:3] == 3'd0 || m[5:3] == 3'd1) ? 1 : 0;
  endfunction
  function automatic int refParOdd(input logic [7:0] m);
    return (m[5:3] == 3'd1) ? 1 : 0;
  endfunction
  function automatic int refStop(input logic [7:0] m);
    return (m[7:6] == 2'b11) ? 1 : 2;
  endfunction
  function automatic int refFrame(input logic [7:0] m);
    return 1 + refData(m) + refParOn(m) + refStop(m);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      since = 0; mM = 8'd0; cdM = 15; bdM = 0;
    end else if (wrEn && wrSel != 2'd3) begin
      case (wrSel)
        2'd0: mM = wrData[7:0];
        2'd1: cdM = int'(wrData);
        default: bdM = int'(wrData[7:0]);
      endcase
      since = 0;
    end else begin
      since++;
    end
  end

  always @(negedge clk) begin
    if (rstN && compareOn) begin
      int per;
      bit et, ec;
      per = (mM[0] ? 8 : 1) * cdM * (bdM + 1);
      et = (cdM >= 2) && (since > 0) && ((since % per) == 0);
      ec = et && (((since / per) % refFrame(mM)) == 0);
      if (baudTick) tickSeen++;
      if (charDone) charSeen++;
      check(baudTick == et, curReq, "baudTick", int'(baudTick), int'(et));
      check(charDone == ec, "R7", "charDone", int'(charDone), int'(ec));
      check(int'(dataBits) == refData(mM), "R3", "dataBits", int'(dataBits), refData(mM));
      check(int'(parityOn) == refParOn(mM) && int'(parityOdd) == refParOdd(mM), "R4",
            "parity", {parityOn, parityOdd}, refParOn(mM) * 2 + refParOdd(mM));
      check(int'(stopBits) == refStop(mM), "R5", "stopBits", int'(stopBits), refStop(mM));
      check(int'(frameBits) == refFrame(mM), "R6", "frameBits", int'(frameBits), refFrame(mM));
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [15:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    idle(3);
    // R1: reset values at the ports
    check(dataBits == 4'd8 && stopBits == 2'd2 && parityOn && !parityOdd, "R1",
          "format", int'(frameBits), 12);
    check(!baudTick && !charDone, "R1", "strobes", int'(baudTick), 0);
    @(negedge clk); rstN = 1'b1;
    compareOn = 1;
    curReq = "R1";
    tickSeen = 0; charSeen = 0;
    idle(400);
    check(tickSeen == 26, "R2", "default tick count", tickSeen, 26);
    check(charSeen == 2, "R7", "default char count", charSeen, 2);

    // R3 R4 R5: decode sweep with a short period
    curReq = "R2";
    wr(2'd1, 16'd4);
    wr(2'd2, 16'd1);
    wr(2'd0, 16'h00C6); idle(200);
    wr(2'd0, 16'h004C); idle(200);
    wr(2'd0, 16'h0022); idle(200);
    wr(2'd0, 16'h001E); idle(200);

    // R2: prescaler on, cascaded dividers, two full characters
    wr(2'd1, 16'd3);
    wr(2'd2, 16'd2);
    tickSeen = 0; charSeen = 0;
    wr(2'd0, 16'h00E1);
    idle(1500);
    check(charSeen == 2, "R2", "prescaled char count", charSeen, 2);

    // R9: restart in the middle of a character
    curReq = "R9";
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'd4);
    wr(2'd2, 16'd1);
    idle(37);
    wr(2'd2, 16'd1);
    idle(300);

    // R10: spare select leaves everything untouched
    curReq = "R10";
    begin
      logic [3:0] fbBefore;
      fbBefore = frameBits;
      idle(5);
      wr(2'd3, 16'hFFFF);
      check(frameBits == fbBefore && dataBits == 4'd8, "R10", "format after spare write",
            int'(frameBits), int'(fbBefore));
    end
    idle(200);

    // R8: divisors 1 and 0 silence the strobes
    curReq = "R8";
    tickSeen = 0;
    wr(2'd1, 16'd1); idle(150);
    wr(2'd1, 16'd0); idle(150);
    check(tickSeen == 0, "R8", "ticks with low divisor", tickSeen, 0);

    // R2: smallest period of two cycles
    curReq = "R2";
    wr(2'd2, 16'd0);
    wr(2'd1, 16'd2);
    idle(100);

    finishRun();
  end

endmodule